// File: doc/BRIEF.md
# Programmable Square-Wave Timer

This block is a down-counting timer that advances on a separate timer clock enable rather than on every system clock. A control register picks either a stopped state or one of seven prescale ratios. A data register holds the reload count. Each prescaled step lowers the main counter by one. On the step that finds the counter at 1, the counter reloads from the data register, the square-wave output inverts and a one-clock interrupt strobe is raised.

Software-facing writes arrive on a simple strobe interface: one strobe loads the control register and one loads the data register, both taking their value from a shared write-data bus. The current count is visible on an output so the surrounding logic can read it. Any control write restarts the prescaler and pulls the wave output low, which lets software start a waveform from a known phase.

Top module: `sqwave_timer`

## Requirements
- R1: A synchronous reset drives wave_out and irq_pulse low and puts the timer in the stopped state. Reset changes neither the data register nor the count: once released, count_q holds its value, and the reload value is the one written before the reset.
- R2: The select field is wdata[2:0], latched on wr_ctrl. Select value 0 means stopped: count_q holds, irq_pulse stays low and wave_out does not change.
- R3: Select values 1 through 7 set the prescale ratio to 4, 10, 16, 50, 64, 100 and 200 counted timer ticks for each count step.
- R4: Each prescaled step lowers count_q by one. The step taken while count_q is 1 reloads count_q from the data register instead. With steady ticks, reload steps are spaced N*D ticks apart, where N is the data value and D is the ratio.
- R5: A data value of 0 acts as a count of 256.
- R6: wave_out inverts on every reload step, so one full output period spans two timer cycles.
- R7: irq_pulse is high for exactly one clock, in the cycle right after a reload step, and at no other time.
- R8: Any wr_ctrl write forces wave_out low in the next cycle and restarts the prescaler from zero. A reload step does not occur on the edge of that write.
- R9: A wr_data write while the timer is stopped also loads count_q on the same edge. A wr_data write while the timer runs leaves count_q unchanged and only affects later reloads.
- R10: Only clock edges with tick_en high advance the prescaler. With tick_en high on every other cycle, the reload spacing doubles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Timer clock enable; one tick per high cycle |
| wr_ctrl | input | 1 | Write strobe for the control register |
| wr_data | input | 1 | Write strobe for the data register |
| wdata | input | CNT_W | Write data; bits [2:0] carry the select field |
| count_q | output | CNT_W | Current main counter value |
| wave_out | output | 1 | Square-wave output |
| irq_pulse | output | 1 | One-clock strobe after each reload |

## Verification
A reload value of 1 is run under every select code, so each ratio shows up on its own as the spacing between wave edges. Larger reload values are run with the slowest and a middle ratio, which separates the count from the prescale. A data value of 0 is tested to confirm that it wraps to 256 and does not stop the timer. A rewrite of the data register during a run is tested to show that only the next reload takes the new value. A control rewrite halfway through a cycle shows that the prescaler restarts while the counter keeps its value. Tick patterns at full rate and at half rate show that the enable, and not the system clock, sets the pace. Reset is applied while the output is high, to show the output clearing while the stored count survives.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // prescale ratio for a select code; code 0 (stopped) maps to 1 so that
  // limit arithmetic never underflows
  function automatic int unsigned divide_of(input int unsigned code);
    case (code)
      1: divide_of = 4;
      2: divide_of = 10;
      3: divide_of = 16;
      4: divide_of = 50;
      5: divide_of = 64;
      6: divide_of = 100;
      7: divide_of = 200;
      default: divide_of = (code == 0) ? 1 : 200;
    endcase
  endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int SEL_W = 3,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  input  logic             restart,
  input  logic             tick_en,
  output logic             step
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] limit;
  logic             running;

  assign running = (sel != '0);
  assign limit   = PRE_W'(tmr_pkg::divide_of(32'(sel)) - 1);
  assign step    = running && tick_en && !restart && !rst && (pre_q == limit);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pre_q <= '0;
    end else if (running && tick_en) begin
      if (pre_q == limit) pre_q <= '0;
      else                pre_q <= pre_q + 1'b1;
    end
  end

endmodule

// File: rtl/tmr_downcount.sv
module tmr_downcount #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             step,
  input  logic             load_now,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count_q,
  output logic             last_step
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign last_step = step && (count_q == ONE);

  // no reset: the count survives a reset by design
  always_ff @(posedge clk) begin
    if (load_now)       count_q <= load_val;
    else if (last_step) count_q <= reload_val;
    else if (step)      count_q <= count_q - 1'b1;
  end

endmodule

// File: rtl/tmr_wave.sv
module tmr_wave (
  input  logic clk,
  input  logic rst,
  input  logic force_low,
  input  logic last_step,
  output logic wave_out,
  output logic irq_pulse
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wave_out  <= 1'b0;
      irq_pulse <= 1'b0;
    end else begin
      irq_pulse <= last_step;
      if (force_low)      wave_out <= 1'b0;
      else if (last_step) wave_out <= ~wave_out;
    end
  end

endmodule

// File: rtl/sqwave_timer.sv
module sqwave_timer #(
  parameter int CNT_W = 8,
  parameter int SEL_W = 3,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             wr_ctrl,
  input  logic             wr_data,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] count_q,
  output logic             wave_out,
  output logic             irq_pulse
);
  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] data_q;
  logic             step;
  logic             last_step;
  logic             load_now;

  always_ff @(posedge clk) begin
    if (rst)          sel_q <= '0;
    else if (wr_ctrl) sel_q <= wdata[SEL_W-1:0];
  end

  // data register is deliberately outside reset
  always_ff @(posedge clk) begin
    if (wr_data) data_q <= wdata;
  end

  assign load_now = wr_data && (sel_q == '0);

  tmr_prescaler #(.SEL_W(SEL_W), .PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .sel     (sel_q),
    .restart (wr_ctrl),
    .tick_en (tick_en),
    .step    (step)
  );

  tmr_downcount #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .step       (step),
    .load_now   (load_now),
    .load_val   (wdata),
    .reload_val (data_q),
    .count_q    (count_q),
    .last_step  (last_step)
  );

  tmr_wave u_wave (
    .clk       (clk),
    .rst       (rst),
    .force_low (wr_ctrl),
    .last_step (last_step),
    .wave_out  (wave_out),
    .irq_pulse (irq_pulse)
  );

endmodule

// File: rtl/sqwave_timer_chk.sv
module sqwave_timer_chk #(
  parameter int CNT_W = 8,
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_ctrl,
  input logic             wr_data,
  input logic [SEL_W-1:0] sel_q,
  input logic [CNT_W-1:0] count_q,
  input logic             wave_out,
  input logic             irq_pulse
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!wave_out && !irq_pulse)); // R1

  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (sel_q == '0 && !wr_ctrl && !wr_data) |=> ($stable(count_q) && !irq_pulse)); // R2

  AST_WAVE_FLIPS_ON_IRQ: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> (wave_out != $past(wave_out))); // R6

  AST_WAVE_STEADY: assert property (@(posedge clk) disable iff (rst)
    (!irq_pulse && !$past(wr_ctrl) && !$past(rst)) |-> $stable(wave_out)); // R6

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |=> !irq_pulse); // R7

  AST_CTRL_FORCES_LOW: assert property (@(posedge clk) disable iff (rst)
    wr_ctrl |=> (!wave_out && !irq_pulse)); // R8

endmodule

bind sqwave_timer sqwave_timer_chk #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_ctrl   (wr_ctrl),
  .wr_data   (wr_data),
  .sel_q     (sel_q),
  .count_q   (count_q),
  .wave_out  (wave_out),
  .irq_pulse (irq_pulse)
);

// File: tb/test_sqwave_timer.sv
module test_sqwave_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b1;
  logic       wr_ctrl = 1'b0;
  logic       wr_data = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] count_q;
  logic       wave_out;
  logic       irq_pulse;
  logic       half_rate = 1'b0;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sqwave_timer i_sqwave_timer (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_ctrl(wr_ctrl),
    .wr_data(wr_data), .wdata(wdata), .count_q(count_q),
    .wave_out(wave_out), .irq_pulse(irq_pulse)
  );

  always @(negedge clk) tick_en <= half_rate ? ~tick_en : 1'b1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input int v);
    @(negedge clk); wr_ctrl = 1'b1; wdata = 8'(v);
    @(negedge clk); wr_ctrl = 1'b0;
  endtask

  task automatic wr_dat(input int v);
    @(negedge clk); wr_data = 1'b1; wdata = 8'(v);
    @(negedge clk); wr_data = 1'b0;
  endtask

  // counts cycles until wave_out changes; checks the interrupt strobe (R7)
  task automatic wait_toggle(output int n);
    logic w0;
    bit early;
    w0 = wave_out; n = 0; early = 0;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      n = n + 1;
      if (wave_out != w0) break;
      if (irq_pulse) early = 1;
    end
    chk("R7 irq high at reload", int'(irq_pulse), 1);
    chk("R7 irq quiet between reloads", int'(early), 0);
  endtask

  task automatic t_reset_state;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 wave low after reset", int'(wave_out), 0);
    chk("R1 irq low after reset", int'(irq_pulse), 0);
  endtask

  task automatic t_stopped_load;
    wr_dat(5);
    chk("R9 stopped data write loads count", int'(count_q), 5);
  endtask

  task automatic t_basic_run;
    int n;
    wr_ctl(1);
    wait_toggle(n);
    chk("R4 first reload spacing 5*4", n, 20);
    chk("R6 wave high after first reload", int'(wave_out), 1);
    chk("R4 count reloaded", int'(count_q), 5);
    wait_toggle(n);
    chk("R6 second reload spacing", n, 20);
    chk("R6 wave low after second reload", int'(wave_out), 0);
  endtask

  task automatic t_divides;
    int n;
    int dv[8] = '{0, 4, 10, 16, 50, 64, 100, 200};
    wr_ctl(0);
    wr_dat(1);
    for (int s = 1; s < 8; s++) begin
      wr_ctl(s);
      chk("R8 wave low after ctrl write", int'(wave_out), 0);
      wait_toggle(n);
      chk($sformatf("R3 ratio for select %0d", s), n, dv[s]);
    end
  endtask

  task automatic t_zero_count;
    int n;
    wr_ctl(0);
    wr_dat(0);
    chk("R5 zero loaded", int'(count_q), 0);
    wr_ctl(1);
    wait_toggle(n);
    chk("R5 zero acts as 256", n, 1024);
  endtask

  task automatic t_force_low;
    int n;
    wr_ctl(0);
    wr_dat(3);
    wr_ctl(2);
    wait_toggle(n);
    chk("R4 spacing 3*10", n, 30);
    chk("R8 wave high before rewrite", int'(wave_out), 1);
    repeat (14) @(negedge clk);
    wr_ctl(2);
    chk("R8 ctrl write forces wave low", int'(wave_out), 0);
    wait_toggle(n);
    chk("R8 prescaler restarted, count kept", n, 20);
  endtask

  task automatic t_run_write_and_stop;
    int n;
    logic [7:0] c;
    wr_ctl(0);
    wr_dat(7);
    wr_ctl(7);
    wr_dat(3);
    chk("R9 running data write leaves count", int'(count_q), 7);
    wait_toggle(n);
    chk("R9 old count used first", n, 1398);
    wait_toggle(n);
    chk("R9 new value used at reload", n, 600);
    repeat (37) @(negedge clk);
    wr_ctl(0);
    c = count_q;
    n = 0;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (count_q != c || irq_pulse || wave_out) n = n + 1;
    end
    chk("R2 stopped timer holds", n, 0);
  endtask

  task automatic t_half_rate;
    int n;
    wr_ctl(0);
    wr_dat(2);
    half_rate = 1'b1;
    wr_ctl(1);
    wait_toggle(n);
    wait_toggle(n);
    chk("R10 half-rate ticks double spacing", n, 16);
    half_rate = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset_keeps;
    int n;
    int c1;
    wr_ctl(0);
    wr_dat(2);
    wr_ctl(1);
    wait_toggle(n);
    chk("R1 wave high before reset", int'(wave_out), 1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 reset drives wave low", int'(wave_out), 0);
    c1 = int'(count_q);
    repeat (30) @(negedge clk);
    chk("R1 reset leaves timer stopped, count held", int'(count_q), c1);
    wr_ctl(1);
    wait_toggle(n);
    chk("R1 count survives reset", n, (c1 == 0 ? 256 : c1) * 4);
    wait_toggle(n);
    chk("R1 data register survives reset", n, 8);
  endtask

  initial begin
    t_reset_state();
    t_stopped_load();
    t_basic_run();
    t_divides();
    t_zero_count();
    t_force_low();
    t_run_write_and_stop();
    t_half_rate();
    t_reset_keeps();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule